// File: doc/BRIEF.md
# SPI Slave Word Engine with Continuous Transfers

This block is the slave end of a serial peripheral link. It runs entirely on a fast system clock and treats the serial clock, the active-low chip select and the serial data input as ordinary asynchronous inputs. It resynchronises them and finds serial clock edges in the system domain. The clock polarity and clock phase inputs choose which serial edge captures incoming data and which edge moves outgoing data. Words travel most significant bit first.

On the parallel side the user sees three things. A one-cycle request strobe asks for the next outgoing word. A write strobe with a data word loads the transmit holding register. A received-word register comes with a one-cycle valid strobe. While chip select stays low and the master keeps clocking, the engine runs word after word with no gap and does not wait for the user. If no new word was written since the last reload, the held word is sent again.

Before the first edge of a transfer, the outgoing line already shows the top bit of the held word. The line switches to the shift register under a registered select, so in phase-1 modes it does not change at the first edge. Raising chip select in the middle of a word drops that word.

Top module: `spi_word_slave`

## Requirements
- R1: In every combination of `mode_cpol` and `mode_cpha`, incoming bits are captured MSB first. With phase 0 they are captured on the leading serial clock edge (the first edge away from the idle level `mode_cpol`). With phase 1 they are captured on the trailing edge. Each completed word appears on `rx_word`.
- R2: Outgoing bits change on the edge opposite to the capture edge. A master sampling on its capture edge reads each transmitted word MSB first.
- R3: While chip select is high, `spi_miso` equals bit WORD_W-1 of the held transmit word. It follows a write one clock after the write strobe.
- R4: With phase 1, `spi_miso` does not change when the engine first switches to the shift register at the first leading edge of a transfer.
- R5: With chip select held low, consecutive words are sequenced without a gap. Every word is received, and the transmitted words follow one another.
- R6: A word boundary reached with no write since the previous reload sends the previously held word again.
- R7: `rx_valid` is a one-cycle pulse after the last bit of a word is captured. `rx_word` holds that word until the next one completes.
- R8: `tx_req` pulses for one cycle per word, when the sample that leaves REQ_LEAD bits of the word still to come is captured.
- R9: Raising chip select mid-word drops the partial word with no `rx_valid`. The next transfer starts at bit WORD_W-1.
- R10: Serial clock and data activity while chip select is high produces no `rx_valid`, no `tx_req`, and no change of `spi_miso`.
- R11: After reset, `rx_valid`, `tx_req`, `rx_word` and the held word are all zero, so `spi_miso` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_cpol | input | 1 | Serial clock idle level |
| mode_cpha | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| tx_req | output | 1 | One-cycle request for the next transmit word |
| tx_we | input | 1 | Write strobe for the transmit holding register |
| tx_word | input | WORD_W | Word to transmit |
| rx_word | output | WORD_W | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |

## Verification
A wrong bit counter shows at the ports within one word. The received words come out shifted, and the request strobe lands on the wrong bit or lands twice. A transmit register that reloads at the wrong moment shows a corrupted word on the outgoing line at the next word boundary. A select that switches early shows as a change of the outgoing line inside the first half bit of a phase-1 transfer. A state that survives chip-select deassertion shows as a stray valid strobe, or as a misaligned first word in the following transfer.

// File: rtl/spi_wslv_pkg.sv
// Package: shared types and the edge-role decoder for the SPI slave word engine.
// Assumes rise/fall flags are single-cycle pulses in the system domain.
package spi_wslv_pkg;

    // Which synchronised serial clock edge does what in the current mode
    typedef struct packed {
        logic sample;   // capture incoming bit
        logic change;   // move outgoing bit
    } spi_evt_t;

    // Map raw edges to capture/change roles from polarity and phase
    function automatic spi_evt_t pick_edges(input logic cpol, input logic cpha,
                                            input logic rise, input logic fall);
        spi_evt_t r;
        logic     lead;
        logic     trail;
        lead     = cpol ? fall : rise;
        trail    = cpol ? rise : fall;
        r.sample = cpha ? trail : lead;
        r.change = cpha ? lead  : trail;
        return r;
    endfunction

endpackage

// File: rtl/spi_line_sync.sv
// Module: resynchronises serial clock, chip select and data into the system
// clock domain and turns serial clock transitions into capture/change pulses.
// Assumes the serial clock half period spans several system clocks.
module spi_line_sync
    import spi_wslv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cpol,
    input  logic     cpha,
    input  logic     sck_pin,
    input  logic     cs_n_pin,
    input  logic     mosi_pin,
    output logic     sel,
    output logic     mosi_s,
    output spi_evt_t evt
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sck_pipe;
    logic [TOP:0] cs_pipe;
    logic [TOP:0] mosi_pipe;
    logic         sck_last;
    logic         rise;
    logic         fall;

    // Flip-flop chains on the three serial inputs plus previous clock level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe  <= '0;
            cs_pipe   <= '1;
            mosi_pipe <= '0;
            sck_last  <= 1'b0;
        end else begin
            sck_pipe  <= {sck_pipe[TOP-1:0], sck_pin};
            cs_pipe   <= {cs_pipe[TOP-1:0], cs_n_pin};
            mosi_pipe <= {mosi_pipe[TOP-1:0], mosi_pin};
            sck_last  <= sck_pipe[TOP];
        end
    end

    assign sel    = ~cs_pipe[TOP];
    assign mosi_s = mosi_pipe[TOP];
    assign rise   = sck_pipe[TOP] & ~sck_last;
    assign fall   = ~sck_pipe[TOP] & sck_last;

    // Edge roles, suppressed while the slave is not selected
    always_comb begin
        evt = pick_edges(cpol, cpha, rise, fall);
        if (!sel) evt = '0;
    end

endmodule

// File: rtl/spi_bit_seq.sv
// Module: bit position counter that wraps every word while selected, flags
// the final capture and raises the transmit request ahead of the word end.
// Assumes 1 <= REQ_LEAD <= WORD_W-1.
module spi_bit_seq #(
    parameter int WORD_W   = 8,
    parameter int REQ_LEAD = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel,
    input  logic                      sample,
    output logic [$clog2(WORD_W)-1:0] bit_cnt,
    output logic                      word_done,
    output logic                      req
);
    localparam int CW     = $clog2(WORD_W);
    localparam int REQ_AT = WORD_W - REQ_LEAD;

    assign word_done = sample && (bit_cnt == CW'(WORD_W - 1));

    // Count captures, wrap at the word end, pulse the request at REQ_AT
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            req     <= 1'b0;
        end else begin
            req <= 1'b0;
            if (!sel) begin
                bit_cnt <= '0;
            end else if (sample) begin
                bit_cnt <= word_done ? '0 : bit_cnt + 1'b1;
                if (bit_cnt == CW'(REQ_AT - 1)) req <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_rx_path.sv
// Module: receive shifter; assembles incoming bits MSB first and publishes a
// complete word with a one-cycle valid strobe.
// Assumes sample pulses arrive only while selected.
module spi_rx_path #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              word_done,
    input  logic              mosi_s,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    logic [WORD_W-1:0] rx_sr;
    logic [WORD_W-1:0] rx_next;

    assign rx_next = {rx_sr[WORD_W-2:0], mosi_s};

    // Shift on each capture and register the finished word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sample) begin
                rx_sr <= rx_next;
                if (word_done) begin
                    rx_word  <= rx_next;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_tx_path.sv
// Module: transmit side; holding register written by the user, shift register
// reloaded at each word start, and a registered output select.
// Assumes the user writes the holding register before the word boundary.
module spi_tx_path #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              change,
    input  logic              at_word_start,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic              miso,
    output logic              hold_msb,
    output logic              shreg_on
);
    logic [WORD_W-1:0] hold_word;
    logic [WORD_W-1:0] tx_sr;

    // Holding register: keeps the last written word until overwritten
    always_ff @(posedge clk) begin
        if (!rst_n) hold_word <= '0;
        else if (we) hold_word <= wdata;
    end

    // Shift register: preload while idle, reload at word start, else shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (!sel) begin
            tx_sr <= hold_word;
        end else if (change) begin
            tx_sr <= at_word_start ? hold_word : {tx_sr[WORD_W-2:0], 1'b0};
        end
    end

    // Output select: moves to the shift register after its first update
    always_ff @(posedge clk) begin
        if (!rst_n) shreg_on <= 1'b0;
        else if (!sel) shreg_on <= 1'b0;
        else if (change) shreg_on <= 1'b1;
    end

    assign hold_msb = hold_word[WORD_W-1];
    assign miso     = shreg_on ? tx_sr[WORD_W-1] : hold_word[WORD_W-1];

endmodule

// File: rtl/spi_word_slave.sv
// Module: top of the SPI slave word engine. Oversamples the serial lines on
// clk, supports all four polarity/phase modes and streams words back to back
// while chip select is low.
// Assumes mode inputs change only while chip select is high.
module spi_word_slave
    import spi_wslv_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int REQ_LEAD    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_cpol,
    input  logic              mode_cpha,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              tx_req,
    input  logic              tx_we,
    input  logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    localparam int CW = $clog2(WORD_W);

    spi_evt_t      evt;
    logic          sel_act;
    logic          mosi_s;
    logic [CW-1:0] bit_cnt;
    logic          word_done;
    logic          hold_msb;
    logic          shreg_on;

    spi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpol     (mode_cpol),
        .cpha     (mode_cpha),
        .sck_pin  (spi_sck),
        .cs_n_pin (spi_cs_n),
        .mosi_pin (spi_mosi),
        .sel      (sel_act),
        .mosi_s   (mosi_s),
        .evt      (evt)
    );

    spi_bit_seq #(.WORD_W(WORD_W), .REQ_LEAD(REQ_LEAD)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel_act),
        .sample    (evt.sample),
        .bit_cnt   (bit_cnt),
        .word_done (word_done),
        .req       (tx_req)
    );

    spi_rx_path #(.WORD_W(WORD_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (evt.sample),
        .word_done (word_done),
        .mosi_s    (mosi_s),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid)
    );

    spi_tx_path #(.WORD_W(WORD_W)) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel           (sel_act),
        .change        (evt.change),
        .at_word_start (bit_cnt == '0),
        .we            (tx_we),
        .wdata         (tx_word),
        .miso          (spi_miso),
        .hold_msb      (hold_msb),
        .shreg_on      (shreg_on)
    );

endmodule

// File: rtl/spi_word_slave_chk.sv
// Module: protocol checker bound to spi_word_slave; watches strobes, idle
// output and the registered output select.
// Assumes the bind below supplies internal nets of the top.
module spi_word_slave_chk #(
    parameter int WORD_W   = 8,
    parameter int REQ_LEAD = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      mode_cpha,
    input logic                      spi_miso,
    input logic                      rx_valid,
    input logic                      tx_req,
    input logic                      sel,
    input logic [$clog2(WORD_W)-1:0] bit_cnt,
    input logic                      hold_msb,
    input logic                      shreg_on
);
    localparam int CW     = $clog2(WORD_W);
    localparam int REQ_AT = WORD_W - REQ_LEAD;

    assert_rx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);

    assert_req_point_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> (bit_cnt == CW'(REQ_AT)));

    assert_idle_miso_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !$past(sel)) |-> (spi_miso == hold_msb));

    assert_no_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel) |-> !rx_valid);

    assert_first_bit_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cpha && $rose(shreg_on)) |-> $stable(spi_miso));

endmodule

bind spi_word_slave spi_word_slave_chk #(.WORD_W(WORD_W), .REQ_LEAD(REQ_LEAD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_cpha (mode_cpha),
    .spi_miso  (spi_miso),
    .rx_valid  (rx_valid),
    .tx_req    (tx_req),
    .sel       (sel_act),
    .bit_cnt   (bit_cnt),
    .hold_msb  (hold_msb),
    .shreg_on  (shreg_on)
);

// File: tb/spi_word_slave_test.sv
// Bench: scoreboard for spi_word_slave. The frame task acts as master, pushes
// expected received words into a queue and a monitor pops them on rx_valid.
module spi_word_slave_test;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_cpol, mode_cpha;
    logic       spi_sck, spi_cs_n, spi_mosi;
    logic       spi_miso;
    logic       tx_req, tx_we;
    logic [7:0] tx_word;
    logic [7:0] rx_word;
    logic       rx_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int req_seen = 0;
    int valid_seen = 0;
    bit done = 0;
    logic [7:0] held;
    logic [7:0] mo_words[$];
    logic [7:0] so_exp[$];
    logic [7:0] resp_q[$];
    logic [7:0] rx_exp[$];

    always #2 clk = ~clk;

    spi_word_slave uut (
        .clk(clk), .rst_n(rst_n), .mode_cpol(mode_cpol), .mode_cpha(mode_cpha),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .tx_req(tx_req), .tx_we(tx_we), .tx_word(tx_word),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard pop on each received word
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rx_valid === 1'b1) begin
            valid_seen++;
            if (rx_exp.size() == 0) chk("R9/R10 unexpected rx_valid", 1, 0);
            else chk("R1 received word", rx_word, rx_exp.pop_front());
        end
        if (rst_n === 1'b1 && tx_req === 1'b1) req_seen++;
    end

    // One clock; answers a pending request from the response queue
    task automatic tick();
        @(negedge clk);
        if (tx_req && resp_q.size() > 0) begin
            tx_word = resp_q.pop_front();
            tx_we   = 1'b1;
        end else begin
            tx_we = 1'b0;
        end
    endtask

    task automatic ticks(input int n, input bit watch, input logic exp_b);
        for (int i = 0; i < n; i++) begin
            tick();
            if (watch) chk("R4 first bit steady", spi_miso, exp_b);
        end
    endtask

    task automatic write_word(input logic [7:0] w);
        @(negedge clk);
        tx_word = w;
        tx_we   = 1'b1;
        @(negedge clk);
        tx_we   = 1'b0;
        held    = w;
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        mode_cpol = pol;
        mode_cpha = pha;
        spi_sck   = pol;
        ticks(4, 0, 1'b0);
    endtask

    // Master frame: n words from mo_words, compares against so_exp
    task automatic run_frame(input int n, input bit glitch_chk);
        int reqs0;
        reqs0 = req_seen;
        spi_cs_n = 1'b0;
        ticks(HALF, 0, 1'b0);
        for (int w = 0; w < n; w++) begin
            logic [7:0] mw;
            logic [7:0] ew;
            logic [7:0] got;
            mw = mo_words.pop_front();
            ew = so_exp.pop_front();
            got = '0;
            rx_exp.push_back(mw);
            for (int b = 7; b >= 0; b--) begin
                if (!mode_cpha) begin
                    spi_mosi = mw[b];
                    ticks(HALF, 0, 1'b0);
                    spi_sck = ~mode_cpol;
                    got[b] = spi_miso;
                    ticks(HALF, 0, 1'b0);
                    spi_sck = mode_cpol;
                end else begin
                    spi_sck = ~mode_cpol;
                    spi_mosi = mw[b];
                    ticks(HALF, glitch_chk && w == 0 && b == 7, ew[7]);
                    spi_sck = mode_cpol;
                    got[b] = spi_miso;
                    ticks(HALF, 0, 1'b0);
                end
            end
            chk("R2 transmitted word", got, ew);
        end
        ticks(HALF, 0, 1'b0);
        spi_cs_n = 1'b1;
        ticks(2 * HALF, 0, 1'b0);
        chk("R5 all words received", rx_exp.size(), 0);
        chk("R8 one request per word", req_seen - reqs0, n);
    endtask

    // Continuous frame of three words with fresh data at each boundary
    task automatic stream3(input logic [7:0] base);
        logic [7:0] r0, r1;
        r0 = base ^ 8'h69;
        r1 = base + 8'h2B;
        mo_words.push_back(base);
        mo_words.push_back(~base);
        mo_words.push_back(base ^ 8'hF0);
        so_exp.push_back(held);
        so_exp.push_back(r0);
        so_exp.push_back(r1);
        resp_q.push_back(r0);
        resp_q.push_back(r1);
        run_frame(3, 1);
        held = r1;
        chk("R7 rx_word holds last word", rx_word, base ^ 8'hF0);
    endtask

    initial begin
        int v0, q0;
        rst_n = 1'b0; spi_cs_n = 1'b1; spi_sck = 1'b0; spi_mosi = 1'b0;
        tx_we = 1'b0; tx_word = '0; mode_cpol = 1'b0; mode_cpha = 1'b0;
        held = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 rx_valid after reset", rx_valid, 0);
        chk("R11 tx_req after reset", tx_req, 0);
        chk("R11 rx_word after reset", rx_word, 0);
        chk("R11 miso after reset", spi_miso, 0);

        write_word(8'hA5);
        chk("R3 idle miso shows held msb", spi_miso, 1);
        write_word(8'h3C);
        chk("R3 idle miso follows write", spi_miso, 0);

        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0]);
            stream3(8'h5A ^ 8'(m * 8'h37));
        end

        // R6: no writes at all, held word repeated three times
        set_mode(1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            mo_words.push_back(8'hC3 + 8'(k));
            so_exp.push_back(held);
        end
        run_frame(3, 0);

        // R6: one write only, that word then repeats
        set_mode(1'b1, 1'b1);
        resp_q.push_back(8'h81);
        mo_words.push_back(8'h12); mo_words.push_back(8'h34); mo_words.push_back(8'h56);
        so_exp.push_back(held); so_exp.push_back(8'h81); so_exp.push_back(8'h81);
        run_frame(3, 1);
        held = 8'h81;

        // R9: abort after four bits, phase 1
        set_mode(1'b0, 1'b1);
        v0 = valid_seen;
        spi_cs_n = 1'b0;
        ticks(HALF, 0, 1'b0);
        for (int b = 0; b < 4; b++) begin
            spi_sck = 1'b1; spi_mosi = b[0]; ticks(HALF, 0, 1'b0);
            spi_sck = 1'b0; ticks(HALF, 0, 1'b0);
        end
        spi_cs_n = 1'b1;
        ticks(3 * HALF, 0, 1'b0);
        chk("R9 aborted word gives no rx_valid", valid_seen - v0, 0);
        mo_words.push_back(8'h9E);
        so_exp.push_back(held);
        run_frame(1, 1);

        // R10: activity while deselected is ignored
        set_mode(1'b0, 1'b0);
        v0 = valid_seen;
        q0 = req_seen;
        for (int k = 0; k < 20; k++) begin
            spi_sck = ~spi_sck; spi_mosi = k[1];
            ticks(3, 0, 1'b0);
            if (spi_miso !== held[7]) chk("R10 miso steady while deselected", spi_miso, held[7]);
        end
        spi_sck = 1'b0;
        ticks(4, 0, 1'b0);
        chk("R10 no rx_valid while deselected", valid_seen - v0, 0);
        chk("R10 no tx_req while deselected", req_seen - q0, 0);
        chk("R10 miso unchanged", spi_miso, held[7]);
        mo_words.push_back(8'h6D);
        so_exp.push_back(held);
        run_frame(1, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: ends a hung run as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule